// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is ready, and afterwards takes care of the refresh obligation. After reset it holds the pins at no-operation, with clock enable high and the data masks high, for a long stable-power wait. It then closes every bank with a precharge-all command. Next it issues a burst of spaced auto-refresh commands and loads the mode register. After a short settling time it raises a done flag.

In normal operation an interval counter measures the refresh period and adds one to a backlog of owed refreshes each time it expires. While refreshes are owed and the sequencer is idle, it raises a request toward the user arbiter. The arbiter answers with a grant only when all banks are idle. A grant makes the sequencer issue one auto-refresh on the next cycle. The backlog can grow to a set cap, and an urgent flag tells the arbiter when the cap is reached. Every delay is a cycle-count parameter, so a bench can shorten the stable wait. No other command is ever driven: on every cycle without a command the pins carry no-operation.

Top module: `sdram_boot_refresh`

## Requirements
- R1: Command cycles are counted from reset release. During reset and in cycles 1 to T_WAIT-1 the command pins carry no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), sd_dqm is all ones and init_done is 0.
- R2: In cycle T_WAIT exactly, a precharge-all is driven: cs_n=0, ras_n=0, cas_n=1, we_n=0, with sd_addr bit 10 high, all other address bits zero and bank zero.
- R3: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) comes T_RP cycles after the precharge-all. N_INIT_REF auto-refreshes follow in total, each T_RC cycles after the one before.
- R4: A mode-register load (all four command pins low) comes T_RC cycles after the last start-up refresh. It carries MODE_WORD on sd_addr with bits 9..7 forced to zero, and bank zero.
- R5: init_done rises T_RSC cycles after the mode-register load and stays high until reset. sd_dqm is all ones before that cycle and all zeros from it on.
- R6: sd_cke is high in every cycle. On every cycle that carries none of the commands above, the pins carry no-operation with sd_addr and sd_ba zero.
- R7: The interval counter starts in the first init_done cycle. One refresh is owed every T_REFI cycles, so the k-th one counts from cycle T_done+k*T_REFI. ref_req is high whenever refreshes are owed and the sequencer is idle in normal operation.
- R8: After init_done, an auto-refresh is driven only in the cycle after ref_gnt was sampled high together with ref_req. A grant during start-up, or while nothing is owed, has no effect.
- R9: With ref_gnt held high, successive refreshes in normal operation are T_RC+1 cycles apart, which is never less than T_RC.
- R10: The backlog saturates at MAX_OWED, and further interval expiries are lost. ref_urgent is high exactly while the backlog equals MAX_OWED.
- R11: An interval expiry in the same cycle as a refresh issue leaves the backlog unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant; all banks are idle |
| ref_req | output | 1 | Refresh owed and sequencer idle |
| ref_urgent | output | 1 | Backlog at its cap |
| init_done | output | 1 | Start-up sequence finished |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Data masks |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |

## Verification
The interval counter can add to the backlog in the same cycle that a granted refresh removes one from it. The bench provokes this by placing a one-cycle grant so that the refresh lands exactly on the cycle when the interval expires. It then judges the result at the ports: ref_req must come back high once the refresh recovery time ends, and a second grant must produce one more refresh. A second overlap, saturation meeting an expiry, is judged by the total number of refreshes needed to drain a full backlog.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // command pins in the order {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_STABLE,
    ST_PREALL,
    ST_BOOTREF,
    ST_LOADMODE,
    ST_GAP,
    ST_RUN,
    ST_RUNREF
  } seq_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int unsigned T_WAIT     = 26700,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RC       = 9,
  parameter int unsigned T_RSC      = 2,
  parameter int unsigned N_INIT_REF = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_gnt,
  input  logic     owed_nz,
  output sdr_cmd_e cmd,
  output logic     done,
  output logic     run_idle,
  output logic     ref_issue
);
  localparam int unsigned TMAX = max2(max2(T_WAIT, T_RP), max2(T_RC, T_RSC));
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned NW   = $clog2(N_INIT_REF + 1);

  seq_state_e     st, nxt;
  logic [TW-1:0]  tmr;
  logic [NW-1:0]  nref;
  logic           done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STABLE;
      nxt    <= ST_PREALL;
      tmr    <= TW'(T_WAIT - 1);
      nref   <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_STABLE:   if (tmr == '0) st <= ST_PREALL; else tmr <= tmr - 1'b1;
        ST_PREALL: begin
          st  <= ST_GAP;
          nxt <= ST_BOOTREF;
          tmr <= TW'(T_RP - 2);
        end
        ST_BOOTREF: begin
          nref <= nref + 1'b1;
          st   <= ST_GAP;
          tmr  <= TW'(T_RC - 2);
          nxt  <= (nref == NW'(N_INIT_REF - 1)) ? ST_LOADMODE : ST_BOOTREF;
        end
        ST_LOADMODE: begin
          st  <= ST_GAP;
          nxt <= ST_RUN;
          tmr <= TW'(T_RSC - 2);
        end
        ST_GAP:      if (tmr == '0) st <= nxt; else tmr <= tmr - 1'b1;
        ST_RUN: begin
          done_q <= 1'b1;
          if (ref_gnt && owed_nz) st <= ST_RUNREF;
        end
        ST_RUNREF: begin
          st  <= ST_GAP;
          nxt <= ST_RUN;
          tmr <= TW'(T_RC - 2);
        end
        default:     st <= ST_STABLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_PREALL:             cmd = CMD_PRE;
      ST_BOOTREF, ST_RUNREF: cmd = CMD_REF;
      ST_LOADMODE:           cmd = CMD_MRS;
      default:               cmd = CMD_NOP;
    endcase
  end

  assign done      = done_q || (st == ST_RUN);
  assign run_idle  = (st == ST_RUN);
  assign ref_issue = (st == ST_RUNREF);

  // R3: the mode load follows only after the full start-up refresh count
  p_boot_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOADMODE) |-> (nref == NW'(N_INIT_REF)));

  // R8: a run-time refresh needs a grant while something was owed
  p_grant_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUNREF) |-> $past(ref_gnt && owed_nz));
endmodule

// File: rtl/sdram_refresh_budget.sv
module sdram_refresh_budget #(
  parameter int unsigned T_REFI   = 2075,
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned IW = $clog2(T_REFI + 1),
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          urgent
);
  logic [IW-1:0] ivl;
  logic          tick;

  // take first, then add, so an expiry at the cap and a take cancel out
  function automatic logic [OW-1:0] next_owed(logic [OW-1:0] cur, logic add, logic sub);
    int unsigned n;
    n = int'(cur);
    if (sub && n > 0) n = n - 1;
    if (add && n < MAX_OWED) n = n + 1;
    return OW'(n);
  endfunction

  assign tick = enable && (ivl == IW'(T_REFI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl  <= '0;
      owed <= '0;
    end else begin
      if (enable) ivl <= tick ? '0 : ivl + 1'b1;
      owed <= next_owed(owed, tick, take);
    end
  end

  assign urgent = (owed == OW'(MAX_OWED));

  p_owed_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));

  p_coincide_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && take) |=> (owed == $past(owed)));

  p_take_needs_owed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (owed != '0));
endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned DQM_W  = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h030
) (
  input  sdr_cmd_e          cmd,
  input  logic              done,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int unsigned AP_BIT = 10;

  function automatic logic [ADDR_W-1:0] mode_bus(logic [ADDR_W-1:0] m);
    logic [ADDR_W-1:0] r;
    r = m;
    r[9:7] = 3'b000;
    return r;
  endfunction

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke = 1'b1;
  assign dqm = done ? '0 : '1;
  assign ba  = '0;

  always_comb begin
    addr = '0;
    if (cmd == CMD_PRE) addr[AP_BIT] = 1'b1;
    else if (cmd == CMD_MRS) addr = mode_bus(MODE_WORD);
  end
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
  import sdram_seq_pkg::*;
#(
  parameter int unsigned T_WAIT     = 26700,
  parameter int unsigned T_RP       = 3,
  parameter int unsigned T_RC       = 9,
  parameter int unsigned T_RSC      = 2,
  parameter int unsigned N_INIT_REF = 8,
  parameter int unsigned T_REFI     = 2075,
  parameter int unsigned MAX_OWED   = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned DQM_W      = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h030
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  localparam int unsigned OW = $clog2(MAX_OWED + 1);
  localparam int unsigned SW = $clog2(T_RC + 1);

  sdr_cmd_e      cmd;
  logic          done, run_idle, ref_issue;
  logic [OW-1:0] owed;

  sdram_seq_fsm #(
    .T_WAIT(T_WAIT), .T_RP(T_RP), .T_RC(T_RC), .T_RSC(T_RSC), .N_INIT_REF(N_INIT_REF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .owed_nz(owed != '0),
    .cmd(cmd), .done(done), .run_idle(run_idle), .ref_issue(ref_issue)
  );

  sdram_refresh_budget #(.T_REFI(T_REFI), .MAX_OWED(MAX_OWED)) u_budget (
    .clk(clk), .rst_n(rst_n), .enable(done), .take(ref_issue),
    .owed(owed), .urgent(ref_urgent)
  );

  sdram_pin_drive #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W), .MODE_WORD(MODE_WORD)
  ) u_pins (
    .cmd(cmd), .done(done), .cke(sd_cke), .cs_n(sd_cs_n), .ras_n(sd_ras_n),
    .cas_n(sd_cas_n), .we_n(sd_we_n), .dqm(sd_dqm), .addr(sd_addr), .ba(sd_ba)
  );

  assign init_done = done;
  assign ref_req   = run_idle && (owed != '0);

  // events seen at the pins, for the checks below
  logic          pin_ref, pin_mrs;
  logic [SW-1:0] since_ref;
  assign pin_ref = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0001);
  assign pin_mrs = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_ref <= SW'(T_RC);
    else if (pin_ref)                 since_ref <= '0;
    else if (since_ref != SW'(T_RC))  since_ref <= since_ref + 1'b1;
  end

  p_ref_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ref |-> (since_ref >= SW'(T_RC - 1)));

  p_ref_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ref && init_done) |-> $past(ref_gnt));

  p_mrs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mrs |-> (sd_addr[9:7] == 3'b000 && sd_ba == '0));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: tb/sdram_boot_refresh_bench.sv
`timescale 1ns/1ps
module sdram_boot_refresh_bench;
  localparam int W = 20, RP = 3, RC = 5, RSC = 4, NR = 8, REFI = 40, MAXO = 8;
  localparam logic [11:0] MODE = 12'h3A7;
  // start-up timeline derived from R2..R5
  localparam int C_PRE  = W;
  localparam int C_REF0 = W + RP;
  localparam int C_MRS  = C_REF0 + (NR - 1) * RC + RC;
  localparam int C_DONE = C_MRS + RSC;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ref_urgent, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [7:0]  sd_dqm;
  logic [11:0] sd_addr;
  logic [1:0]  sd_ba;
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;

  sdram_boot_refresh #(
    .T_WAIT(W), .T_RP(RP), .T_RC(RC), .T_RSC(RSC), .N_INIT_REF(NR),
    .T_REFI(REFI), .MAX_OWED(MAXO), .MODE_WORD(MODE)
  ) u_sdram_boot_refresh (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .init_done(init_done), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // R1: values held while in reset
  task automatic t_reset();
    chk("R1 reset cmd", pins(), 4'b0111);
    chk("R1 reset dqm", sd_dqm, 8'hFF);
    chk("R6 reset cke", sd_cke, 1'b1);
    chk("R1 reset done", init_done, 1'b0);
    chk("R7 reset req", ref_req, 1'b0);
  endtask

  // R1..R6 with ref_gnt held high throughout (R8: ignored during start-up)
  task automatic t_startup();
    for (int c = 1; c <= C_DONE + 3; c++) begin
      logic [3:0]  ec;
      logic [11:0] ea;
      string       tag;
      wait_cyc(c);
      ec = 4'b0111; ea = 12'h000; tag = (c < W) ? "R1 wait nop" : "R6 idle nop";
      if (c == C_PRE) begin ec = 4'b0010; ea = 12'h400; tag = "R2 precharge-all"; end
      else if (c >= C_REF0 && c < C_MRS && (c - C_REF0) % RC == 0) begin
        ec = 4'b0001; tag = "R3 start-up refresh";
      end else if (c == C_MRS) begin
        ec = 4'b0000; ea = MODE & ~12'h380; tag = "R4 mode load";
      end
      chk(tag, pins(), ec);
      chk(tag, sd_addr, ea);
      chk("R6 bank zero", sd_ba, 2'b00);
      chk("R6 cke high", sd_cke, 1'b1);
      chk("R5 dqm", sd_dqm, (c < C_DONE) ? 8'hFF : 8'h00);
      chk("R5 init_done", init_done, c >= C_DONE);
    end
  endtask

  // R8: grant held while nothing is owed gives no refresh; R7 first request
  task automatic t_idle_grant();
    for (int c = C_DONE + 4; c <= C_DONE + REFI - 1; c++) begin
      wait_cyc(c);
      chk("R8 no refresh without debt", pins(), 4'b0111);
      chk("R7 no request yet", ref_req, 1'b0);
    end
    ref_gnt = 1'b0;
    wait_cyc(C_DONE + REFI);
    chk("R7 request after one interval", ref_req, 1'b1);
  endtask

  // R10: backlog grows to the cap, urgent exactly at the cap
  task automatic t_backlog();
    wait_cyc(C_DONE + (MAXO - 1) * REFI);
    chk("R10 urgent below cap", ref_urgent, 1'b0);
    wait_cyc(C_DONE + MAXO * REFI - 1);
    chk("R10 urgent below cap", ref_urgent, 1'b0);
    wait_cyc(C_DONE + MAXO * REFI);
    chk("R10 urgent at cap", ref_urgent, 1'b1);
    chk("R7 request at cap", ref_req, 1'b1);
    wait_cyc(C_DONE + (MAXO + 1) * REFI + 2);
    chk("R10 urgent held after lost expiry", ref_urgent, 1'b1);
  endtask

  // R9/R10: drain a saturated backlog with grant held high
  task automatic t_drain();
    int g0, last, nref;
    g0 = C_DONE + (MAXO + 1) * REFI + 3;   // cycle 430
    wait_cyc(g0);
    ref_gnt = 1'b1;
    last = -1; nref = 0;
    for (int c = g0 + 1; c <= g0 + 62; c++) begin
      wait_cyc(c);
      if (pins() == 4'b0001) begin
        if (last < 0) chk("R8 refresh one cycle after grant", c, g0 + 1);
        else          chk("R9 refresh spacing", c - last, RC + 1);
        last = c; nref++;
      end
    end
    ref_gnt = 1'b0;
    // 8 at the cap (the 9th expiry was lost) plus the 10th expiry during drain
    chk("R10 refreshes to drain", nref, MAXO + 1);
    chk("R7 request clear after drain", ref_req, 1'b0);
    chk("R10 urgent clear after drain", ref_urgent, 1'b0);
  endtask

  // R11: refresh issue lands on the cycle of an interval expiry
  task automatic t_coincide();
    int tk;
    tk = C_DONE + 12 * REFI - 1;           // 12th expiry, cycle 546
    wait_cyc(C_DONE + 11 * REFI);
    chk("R7 request after 11th expiry", ref_req, 1'b1);
    wait_cyc(tk - 1);
    ref_gnt = 1'b1;
    wait_cyc(tk);
    ref_gnt = 1'b0;
    chk("R11 refresh on expiry cycle", pins(), 4'b0001);
    wait_cyc(tk + 1);
    chk("R8 no refresh during recovery", pins(), 4'b0111);
    wait_cyc(tk + RC);
    chk("R11 debt kept after coincidence", ref_req, 1'b1);
    wait_cyc(tk + RC + 1);
    ref_gnt = 1'b1;
    wait_cyc(tk + RC + 2);
    ref_gnt = 1'b0;
    chk("R11 kept debt refreshed", pins(), 4'b0001);
    wait_cyc(tk + 2 * RC + 3);
    chk("R11 debt cleared", ref_req, 1'b0);
  endtask

  initial begin
    ref_gnt = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_startup();
    t_idle_grant();
    t_backlog();
    t_drain();
    t_coincide();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule